// File: doc/BRIEF.md
# Multi-channel FIFO event interrupt aggregator

This block gathers FIFO status flags from ten capture channels and ten playback channel pairs (channel c carries one capture and one playback FIFO, six flags in all) and reduces them to a single interrupt line toward the processor. Each flag is watched for a rising edge; an edge is remembered in a sticky raw-status bit that software removes by writing one to the matching clear bit. Per-event enables turn raw status into masked status, and a second enable layer, one bit per channel, decides whether a channel's masked events may drive the interrupt line.

Software reaches the block through a plain single-cycle register port: a write takes effect on the clock edge where the write strobe is high, and read data is a combinational function of the address and the current register state. There is no handshake and no back-pressure on this port; a write is always accepted and a read is always valid in the same cycle. The flag inputs are plain level signals, sampled every clock.

Each channel owns an 8-bit lane in a 32-bit word, four channels per word, so ten channels span three words per register kind.

Top module: `chan_evt_irq_agg`

## Requirements
- R1: Within a lane, bit 0 is capture almost-empty, bit 1 capture almost-full, bit 2 playback almost-empty, bit 3 playback almost-full, bit 4 capture overflow, bit 5 playback overflow; flag input bit c*6+e carries event e of channel c.
- R2: Channel c sits in word (c div 4) of each register kind, at bit offset 8*(c mod 4).
- R3: Word addresses: 0–2 event enable, 3–5 clear, 6–8 raw status, 9–11 masked status, 12 channel enable (bit c for channel c); addresses 13–15 read zero and ignore writes.
- R4: A raw bit is set on the cycle after a rising edge of its flag and stays set while the flag level stays high or falls; a flag held high does not set the bit again once cleared.
- R5: Writing a one to a clear bit removes that raw bit; clear bits written as zero leave raw status unchanged.
- R6: If a clear and a new rising edge of the same event land in the same cycle, the raw bit stays set.
- R7: Masked status reads raw status AND event enable, bit for bit; event enables read back as written.
- R8: The interrupt output is high exactly while some channel has its channel-enable bit set and at least one masked bit.
- R9: Lane bits 6–7, lanes 2–3 of word 2 and channel-enable bits 10–31 read zero and ignore writes.
- R10: Raw and masked words ignore writes; clear words read zero.
- R11: After reset all registers read zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_flags_i | input | 60 | FIFO flag levels, bit c*6+e for event e of channel c |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Aggregated interrupt line |

## Verification
The assertions take for granted that the flag inputs and the register port are stable and free of unknowns at each rising clock edge, and that reset is held for at least one edge before checking starts. The stimulus keeps to this by changing every input only on the falling clock edge, holding reset low with all flags low for several cycles, and driving only defined values, including in the long stretch where flags, writes and addresses are drawn at random.

// File: rtl/agg_pkg.sv
package agg_pkg;
  localparam int unsigned EVT_N  = 6;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / LANE_W;

  typedef enum logic [2:0] {
    EV_CAP_AE  = 3'd0,
    EV_CAP_AF  = 3'd1,
    EV_PLY_AE  = 3'd2,
    EV_PLY_AF  = 3'd3,
    EV_CAP_OVF = 3'd4,
    EV_PLY_OVF = 3'd5
  } evt_kind_e;

  typedef logic [EVT_N-1:0] evt_vec_t;

  // Bits of a word that never hold an event, whatever the bank.
  function automatic logic [WORD_W-1:0] lane_pad_mask();
    logic [WORD_W-1:0] m;
    m = '1;
    for (int l = 0; l < int'(LANES); l++) begin
      for (int e = 0; e < int'(EVT_N); e++) begin
        m[l*LANE_W + e] = 1'b0;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/agg_evt_latch.sv
module agg_evt_latch
  import agg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t flag_i,
  input  evt_vec_t clr_i,
  output evt_vec_t raw_o
);
  evt_vec_t flag_q;
  evt_vec_t raw_q;
  evt_vec_t rise;

  assign rise  = flag_i & ~flag_q;
  assign raw_o = raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      raw_q  <= '0;
    end else begin
      flag_q <= flag_i;
      raw_q  <= (raw_q & ~clr_i) | rise;
    end
  end

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((raw_q & $past(rise)) == $past(rise))); // R6

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~rise) != '0) |=> ((raw_q & $past(clr_i & ~rise)) == '0)); // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~$past(raw_q) & ~$past(rise)) == '0)); // R4
endmodule

// File: rtl/agg_regs.sv
module agg_regs
  import agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [WORD_W-1:0]         wdata_i,
  output logic [NUM_CH*EVT_N-1:0]   en_o,
  output logic [NUM_CH*EVT_N-1:0]   clr_o,
  output logic [NUM_CH-1:0]         chen_o
);
  localparam int unsigned NUM_BANK  = (NUM_CH + LANES - 1) / LANES;
  localparam int unsigned EN_BASE   = 0;
  localparam int unsigned CLR_BASE  = NUM_BANK;
  localparam int unsigned CHEN_ADDR = 4 * NUM_BANK;

  logic [NUM_CH-1:0] chen_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign chen_o       = chen_q;

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
    localparam int unsigned BANK = c / LANES;
    localparam int unsigned LANE = c % LANES;
    evt_vec_t en_q;
    logic     hit_en;
    logic     hit_clr;

    assign hit_en  = wr_i && (addr_i == ADDR_W'(EN_BASE + BANK));
    assign hit_clr = wr_i && (addr_i == ADDR_W'(CLR_BASE + BANK));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q <= '0;
      end else if (hit_en) begin
        en_q <= wdata_i[LANE*LANE_W +: EVT_N];
      end
    end

    assign en_o[c*EVT_N +: EVT_N]  = en_q;
    assign clr_o[c*EVT_N +: EVT_N] = hit_clr ? wdata_i[LANE*LANE_W +: EVT_N] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chen_q <= '0;
    end else if (wr_i && (addr_i == ADDR_W'(CHEN_ADDR))) begin
      chen_q <= wdata_i[NUM_CH-1:0];
    end
  end

  AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> wr_i); // R5

  AST_EN_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(en_o) && $stable(chen_o))); // R3
endmodule

// File: rtl/agg_rdmux.sv
module agg_rdmux
  import agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [NUM_CH*EVT_N-1:0]   en_i,
  input  logic [NUM_CH*EVT_N-1:0]   raw_i,
  input  logic [NUM_CH*EVT_N-1:0]   masked_i,
  input  logic [NUM_CH-1:0]         chen_i,
  output logic [WORD_W-1:0]         rdata_o
);
  localparam int unsigned NUM_BANK  = (NUM_CH + LANES - 1) / LANES;
  localparam int unsigned EN_BASE   = 0;
  localparam int unsigned RAW_BASE  = 2 * NUM_BANK;
  localparam int unsigned MSK_BASE  = 3 * NUM_BANK;
  localparam int unsigned CHEN_ADDR = 4 * NUM_BANK;
  localparam logic [WORD_W-1:0] PAD = lane_pad_mask();

  logic [WORD_W-1:0] contrib [NUM_CH];

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
    localparam int unsigned BANK = c / LANES;
    localparam int unsigned LANE = c % LANES;
    logic [WORD_W-1:0] part;

    always_comb begin
      part = '0;
      if (addr_i == ADDR_W'(EN_BASE + BANK)) begin
        part[LANE*LANE_W +: EVT_N] = en_i[c*EVT_N +: EVT_N];
      end else if (addr_i == ADDR_W'(RAW_BASE + BANK)) begin
        part[LANE*LANE_W +: EVT_N] = raw_i[c*EVT_N +: EVT_N];
      end else if (addr_i == ADDR_W'(MSK_BASE + BANK)) begin
        part[LANE*LANE_W +: EVT_N] = masked_i[c*EVT_N +: EVT_N];
      end
    end

    assign contrib[c] = part;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CHEN_ADDR)) begin
      rdata_o[NUM_CH-1:0] = chen_i;
    end else begin
      for (int c = 0; c < int'(NUM_CH); c++) begin
        rdata_o = rdata_o | contrib[c];
      end
    end
  end

  AST_LANE_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i != ADDR_W'(CHEN_ADDR)) |-> ((rdata_o & PAD) == '0)); // R9
endmodule

// File: rtl/chan_evt_irq_agg.sv
module chan_evt_irq_agg
  import agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH*EVT_N-1:0]   evt_flags_i,
  input  logic                      reg_wr_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [WORD_W-1:0]         reg_wdata_i,
  output logic [WORD_W-1:0]         reg_rdata_o,
  output logic                      irq_o
);
  logic [NUM_CH*EVT_N-1:0] en_flat;
  logic [NUM_CH*EVT_N-1:0] clr_flat;
  logic [NUM_CH*EVT_N-1:0] raw_flat;
  logic [NUM_CH*EVT_N-1:0] masked_flat;
  logic [NUM_CH-1:0]       chen;
  logic [NUM_CH-1:0]       ch_hit;

  agg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .en_o    (en_flat),
    .clr_o   (clr_flat),
    .chen_o  (chen)
  );

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
    agg_evt_latch latch_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (evt_flags_i[c*EVT_N +: EVT_N]),
      .clr_i  (clr_flat[c*EVT_N +: EVT_N]),
      .raw_o  (raw_flat[c*EVT_N +: EVT_N])
    );
    assign ch_hit[c] = chen[c] & (|masked_flat[c*EVT_N +: EVT_N]);
  end

  assign masked_flat = raw_flat & en_flat;
  assign irq_o       = |ch_hit;

  agg_rdmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) rdmux_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (reg_addr_i),
    .en_i     (en_flat),
    .raw_i    (raw_flat),
    .masked_i (masked_flat),
    .chen_i   (chen),
    .rdata_o  (reg_rdata_o)
  );

  AST_IRQ_NEEDS_CHEN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (chen != '0)); // R8

  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (raw_flat != '0)); // R8

  AST_IRQ_QUIET_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_flat == '0) |-> !irq_o); // R7
endmodule

// File: tb/chan_evt_irq_agg_tb_top.sv
`timescale 1ns/1ps
module chan_evt_irq_agg_tb_top;
  localparam int NCH = 10;
  localparam int NEV = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH*NEV-1:0] flags = '0;
  logic            wr = 1'b0;
  logic [3:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit m_raw  [NCH][NEV];
  bit m_en   [NCH][NEV];
  bit m_prev [NCH][NEV];
  bit m_chen [NCH];

  always #2.5 clk = ~clk;

  chan_evt_irq_agg dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_flags_i (flags),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit model_irq();
    for (int c = 0; c < NCH; c++)
      for (int e = 0; e < NEV; e++)
        if (m_chen[c] && m_raw[c][e] && m_en[c][e]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] model_word(int a);
    logic [31:0] w = '0;
    if (a == 12) begin
      for (int c = 0; c < NCH; c++) w[c] = m_chen[c];
    end else if (a < 12 && (a < 3 || a >= 6)) begin
      for (int l = 0; l < 4; l++) begin
        int c = (a % 3) * 4 + l;
        if (c < NCH)
          for (int e = 0; e < NEV; e++) begin
            if (a < 3)      w[l*8+e] = m_en[c][e];
            else if (a < 9) w[l*8+e] = m_raw[c][e];
            else            w[l*8+e] = m_raw[c][e] & m_en[c][e];
          end
      end
    end
    return w;
  endfunction

  // One clock with the inputs as currently driven; model steps alongside.
  task automatic tick();
    bit n_raw [NCH][NEV];
    for (int c = 0; c < NCH; c++) begin
      for (int e = 0; e < NEV; e++) begin
        bit f   = flags[c*NEV+e];
        bit rs  = f && !m_prev[c][e];
        bit clr = wr && (int'(addr) == 3 + c/4) && wdata[(c%4)*8+e];
        n_raw[c][e] = (m_raw[c][e] && !clr) || rs;
      end
    end
    for (int c = 0; c < NCH; c++) begin
      for (int e = 0; e < NEV; e++) begin
        m_raw[c][e]  = n_raw[c][e];
        m_prev[c][e] = flags[c*NEV+e];
        if (wr && int'(addr) == c/4) m_en[c][e] = wdata[(c%4)*8+e];
      end
      if (wr && addr == 4'd12) m_chen[c] = wdata[c];
    end
    @(posedge clk);
    @(negedge clk);
    check("R8 irq per cycle", {31'd0, irq}, {31'd0, model_irq()});
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    wr = 1'b1; addr = 4'(a); wdata = d;
    tick();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_check(int a, string tag);
    addr = 4'(a);
    #0.5;
    check(tag, rdata, model_word(a));
  endtask

  task automatic set_flag(int c, int e, bit v);
    flags[c*NEV+e] = v;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 irq after reset", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a); #0.5;
      check("R11 register zero after reset", rdata, 32'd0);
    end

    // R9 unused lane bits and lanes of the last bank
    wr_reg(0, 32'hFFFF_FFFF);
    rd_check(0, "R9 lane padding bank0");
    check("R9 bank0 value", rdata, 32'h3F3F_3F3F);
    wr_reg(2, 32'hFFFF_FFFF);
    rd_check(2, "R9 bank2 upper lanes");
    check("R9 bank2 value", rdata, 32'h0000_3F3F);
    wr_reg(12, 32'hFFFF_FFFF);
    check("R9 channel enable width", rdata, 32'h0000_03FF);
    wr_reg(13, 32'hFFFF_FFFF);
    rd_check(13, "R3 address 13 reads zero");

    // R1 R2: channel 1 capture almost-full -> bank0 bit 9
    set_flag(1, 1, 1'b1);
    tick();
    rd_check(6, "R2 raw bank0");
    check("R1 raw bit position", rdata, 32'h0000_0200);
    rd_check(9, "R7 masked bank0");
    check("R8 irq with source", {31'd0, irq}, 32'd1);

    // R4 held level does not relatch after clear
    wr_reg(3, 32'h0000_0200);
    tick(); tick();
    rd_check(6, "R4 held level not relatched");
    check("R4 raw cleared", rdata, 32'd0);
    set_flag(1, 1, 1'b0); tick();
    set_flag(1, 1, 1'b1); tick();
    rd_check(6, "R4 new edge relatches");

    // R5 zero clear bits are harmless, one clears
    wr_reg(3, 32'h0000_0000);
    rd_check(6, "R5 zero clear no effect");
    check("R5 raw kept", rdata, 32'h0000_0200);
    wr_reg(4, 32'h0000_0200);
    rd_check(6, "R5 clear wrong bank no effect");
    wr_reg(3, 32'hFFFF_FFFF);
    rd_check(6, "R5 clear one");

    // R6 clear on the same cycle as a new edge: channel 9 playback overflow
    set_flag(9, 5, 1'b1); tick();
    set_flag(9, 5, 1'b0); tick();
    rd_check(8, "R2 raw bank2 lane1");
    check("R6 pre set", rdata, 32'h0000_2000);
    set_flag(9, 5, 1'b1);
    wr_reg(5, 32'h0000_2000);
    rd_check(8, "R6 clear with edge keeps bit");
    check("R6 value", rdata, 32'h0000_2000);

    // R7 enable gating, R8 channel enable gating
    wr_reg(2, 32'h0000_001F);
    rd_check(11, "R7 masked off by enable");
    rd_check(8, "R7 raw unchanged");
    wr_reg(2, 32'h0000_3F00);
    rd_check(11, "R7 masked on");
    wr_reg(12, 32'h0000_01FF);
    check("R8 channel enable blocks irq", {31'd0, irq}, {31'd0, model_irq()});
    wr_reg(12, 32'h0000_03FF);

    // R10 read-only words ignore writes, clear words read zero
    wr_reg(8, 32'h0000_0000);
    rd_check(8, "R10 raw ignores write");
    wr_reg(11, 32'hFFFF_FFFF);
    rd_check(11, "R10 masked ignores write");
    rd_check(5, "R10 clear reads zero");

    // Mixed stimulus against the model
    for (int i = 0; i < 2000; i++) begin
      flags = {$urandom, $urandom} & {2{$urandom | $urandom}};
      wr    = ($urandom % 3) == 0;
      addr  = 4'($urandom % 16);
      wdata = $urandom;
      tick();
      wr = 1'b0;
      rd_check(int'($urandom % 16), "R3 mixed readback");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule